// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit

This block is a purely combinational 32-bit integer adder/subtractor for a datapath. One control input picks addition or subtraction. A second input picks whether the operands are read as signed or unsigned numbers.

Subtraction uses the same single adder as addition. The block inverts the second operand and feeds a carry-in of one, so A - B is formed as A + ~B + 1.

The block always exposes the carry out of the top bit, so later logic can test unsigned range itself. The overflow flag is driven only in signed mode. It is set when the two values entering the adder have the same sign and the result's sign differs from it. In unsigned mode the flag is held low.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_en` = 0, `sum` equals (`op_a` + `op_b`) modulo 2^32, in both modes.
- R2: With `sub_en` = 1, `sum` equals (`op_a` - `op_b`) modulo 2^32, in both modes.
- R3: With `sub_en` = 0, `carry_out` is bit 32 of the 33-bit unsigned sum of `op_a` and `op_b`.
- R4: With `sub_en` = 1, `carry_out` is the carry of `op_a` + ~`op_b` + 1. It is 1 exactly when `op_a` >= `op_b` as unsigned numbers, and 0 when a borrow occurs.
- R5: With `signed_en` = 1, `ovf` is 1 when both adder inputs (`op_a`, and `op_b` or its inverse for subtract) have bit 31 = 0 and `sum` bit 31 = 1.
- R6: With `signed_en` = 1, `ovf` is 1 when both adder inputs have bit 31 = 1 and `sum` bit 31 = 0.
- R7: With `signed_en` = 1, `ovf` is 0 whenever the two adder inputs differ in bit 31. For example, adding a positive and a negative value never flags. More generally, with `signed_en` = 1, `ovf` is 1 exactly when the true signed result does not fit in 32 bits.
- R8: With `signed_en` = 0, `ovf` is 0 for both add and subtract. `sum` and `carry_out` are the same as in signed mode for the same operands and operation.
- R9: Outputs depend only on the present inputs; no clock or stored state is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 selects A - B, 0 selects A + B |
| signed_en | input | 1 | 1 selects signed interpretation, enabling the overflow flag |
| sum | output | 32 | Result, modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 of the adder |
| ovf | output | 1 | Signed overflow; always 0 in unsigned mode |

## Verification
The assertions are evaluated whenever any input changes. They assume that the control and operand inputs hold two-state values: an unknown `sub_en` or `signed_en` has no defined result, and the checks do not model one. The directed stimulus drives only fully known values. Each operand set is applied, then held for a nanosecond before the outputs are sampled, so every comparison sees settled logic. The vectors pick the sign boundary values (0, 1, the largest positive, the most negative, all ones) so that both overflow directions, opposite-sign sums and borrow/no-borrow carries are each reached.

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  input  logic             signed_en,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_in;
  logic [WIDTH:0]   total;
  logic             same_in_sign;
  logic             sign_flip;

  assign b_in  = sub_en ? ~op_b : op_b;
  assign total = {1'b0, op_a} + {1'b0, b_in} + {{WIDTH{1'b0}}, sub_en};

  assign sum       = total[MSB:0];
  assign carry_out = total[WIDTH];

  assign same_in_sign = ~(op_a[MSB] ^ b_in[MSB]);
  assign sign_flip    = op_a[MSB] ^ total[MSB];
  assign ovf          = signed_en & same_in_sign & sign_flip;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_en,
  input logic             signed_en,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!sub_en) AST_ADD_SUM: assert (sum == op_a + op_b); // R1
    if (sub_en) AST_SUB_SUM: assert (sum == op_a - op_b); // R2
    if (!sub_en) AST_ADD_CARRY: assert (carry_out == (({1'b0, op_a} + {1'b0, op_b}) >> WIDTH)); // R3
    if (sub_en) AST_SUB_CARRY: assert (carry_out == (op_a >= op_b)); // R4
    if (signed_en && !sub_en && !op_a[MSB] && !op_b[MSB] && sum[MSB])
      AST_POS_WRAP: assert (ovf); // R5
    if (signed_en && !sub_en && op_a[MSB] && op_b[MSB] && !sum[MSB])
      AST_NEG_WRAP: assert (ovf); // R6
    if (signed_en && !sub_en && (op_a[MSB] != op_b[MSB]))
      AST_MIXED_ADD: assert (!ovf); // R7
    if (signed_en && sub_en && (op_a[MSB] == op_b[MSB]))
      AST_MIXED_SUB: assert (!ovf); // R7
    if (!signed_en) AST_NO_OVERFLOW: assert (!ovf); // R8
  end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .signed_en(signed_en),
  .sum(sum), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sub_en = 1'b0, signed_en = 1'b0;
  logic [31:0] sum;
  logic        carry_out, ovf;
  int          n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  addsub_unit u0 (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .signed_en(signed_en),
    .sum(sum), .carry_out(carry_out), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h sub=%0b sgn=%0b)",
               req, act, exp, op_a, op_b, sub_en, signed_en);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s, input logic sg);
    @(negedge clk);
    op_a = a; op_b = b; sub_en = s; signed_en = sg;
    #1;
  endtask

  function automatic logic ref_ovf(input logic [31:0] a, input logic [31:0] b, input logic s);
    longint ex;
    ex = s ? (longint'($signed(a)) - longint'($signed(b)))
           : (longint'($signed(a)) + longint'($signed(b)));
    return (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
  endfunction

  task automatic vec(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic s, input logic sg);
    logic [32:0] wide;
    apply(a, b, s, sg);
    wide = s ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
    chk({req, " sum"}, {2'b0, sum}, {2'b0, s ? a - b : a + b});
    chk({req, " carry"}, {33'b0, carry_out}, {33'b0, s ? (a >= b) : wide[32]});
    chk({req, " ovf"}, {33'b0, ovf}, {33'b0, sg & ref_ovf(a, b, s)});
  endtask

  task automatic t_reset_state;
    apply(32'h0, 32'h0, 1'b0, 1'b0);
    chk("R9 idle sum", {2'b0, sum}, 34'h0);
    chk("R9 idle flags", {32'b0, carry_out, ovf}, 34'h0);
  endtask

  task automatic t_plain_add;
    vec("R1", 32'd1000, 32'd9000, 1'b0, 1'b1);
    vec("R1", 32'h1234_5678, 32'h0FED_CBA9, 1'b0, 1'b0);
    vec("R3", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    vec("R3", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_plain_sub;
    vec("R2", 32'd7, 32'd2, 1'b1, 1'b1);
    vec("R2", 32'd2, 32'd7, 1'b1, 1'b1);
    vec("R4", 32'd5, 32'd5, 1'b1, 1'b0);
    vec("R4", 32'h0, 32'h1, 1'b1, 1'b0);
    vec("R4", 32'h0, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_pos_overflow;
    vec("R5", 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    chk("R5 flag", {33'b0, ovf}, 34'h1);
    vec("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    chk("R5 sub flag", {33'b0, ovf}, 34'h1);
  endtask

  task automatic t_neg_overflow;
    vec("R6", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1);
    chk("R6 flag", {33'b0, ovf}, 34'h1);
    vec("R6", 32'h8000_0000, 32'h1, 1'b1, 1'b1);
    chk("R6 sub flag", {33'b0, ovf}, 34'h1);
  endtask

  task automatic t_mixed_signs;
    vec("R7", 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b1);
    chk("R7 flag", {33'b0, ovf}, 34'h0);
    vec("R7", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
    vec("R7", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);
    chk("R7 sub flag", {33'b0, ovf}, 34'h0);
  endtask

  task automatic t_unsigned_mode;
    logic [31:0] s_sum;
    logic        s_cy;
    apply(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    s_sum = sum; s_cy = carry_out;
    apply(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0);
    chk("R8 add ovf", {33'b0, ovf}, 34'h0);
    chk("R8 add same", {1'b0, carry_out, sum}, {1'b0, s_cy, s_sum});
    apply(32'h8000_0000, 32'h1, 1'b1, 1'b1);
    s_sum = sum; s_cy = carry_out;
    apply(32'h8000_0000, 32'h1, 1'b1, 1'b0);
    chk("R8 sub ovf", {33'b0, ovf}, 34'h0);
    chk("R8 sub same", {1'b0, carry_out, sum}, {1'b0, s_cy, s_sum});
  endtask

  task automatic t_sweep;
    logic [31:0] pts [6];
    pts = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h5555_AAAA};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 4; k++)
          vec("R7 sweep", pts[i], pts[j], k[0], k[1]);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_plain_add();
        t_plain_sub();
        t_pos_overflow();
        t_neg_overflow();
        t_mixed_signs();
        t_unsigned_mode();
        t_sweep();
      end
      begin
        repeat (50000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule